// File: doc/BRIEF.md
# Linkable Audio Channel Divider Bank

The block holds four programmable divide-by-N counters, one for each audio channel. Each counter gives a one-cycle pulse every N+1 of its input ticks. The noise, filter and tone stages downstream use these pulses as their per-channel rate clocks.

A control byte sets where each counter takes its ticks from:
- All four counters share a base tick. An internal prescaler builds the base tick from the system-rate enable, in either a fast or a slow form.
- Channels 0 and 2 can instead run directly from the system-rate enable.
- Channels 1 and 3 can instead count the pulses of their lower neighbour. The neighbour pair then forms a single 16-bit divider, and only the upper channel drives an output pulse.

Each period register is written through its own strobe and a shared data bus. The counter loads the new value only when it next reloads.

Top module: `audio_div_bank`

## Requirements
- R1: While rst_ni is low, all period registers and counters clear. After reset, div_pulse_o is 0 in every cycle where sys_tick_i is 0.
- R2: A channel with period register value N and a steady tick source gives a pulse exactly one cycle wide once every N+1 source ticks.
- R3: With ctrl_i bit 0 = 0, the base tick fires once every 28 sys_tick_i cycles. With bit 0 = 1, it fires once every 114 sys_tick_i cycles. This selection applies to all channels that run from the base tick.
- R4: ctrl_i bit 6 = 1 clocks channel 0 from sys_tick_i. ctrl_i bit 5 = 1 clocks channel 2 from sys_tick_i.
- R5: ctrl_i bit 4 = 1 clocks channel 1 from the pulses of channel 0. ctrl_i bit 3 = 1 clocks channel 3 from the pulses of channel 2. The upper channel's pulse period is then (lo+1)*(hi+1) ticks of the lower channel's source.
- R6: While a pair is chained (bit 4 for channels 0/1, bit 3 for channels 2/3), the lower channel's bit of div_pulse_o stays 0.
- R7: A period write that lands in the middle of a count does not change the interval in progress. The new value sets the interval that follows the next reload.
- R8: A pulse on any channel appears only in a cycle where sys_tick_i is 1.
- R9: The system-clock select bits apply only to channels 0 and 2. Channel 1 stays on the base tick when ctrl_i bit 6 is set.

Port order below follows the module declaration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_tick_i | input | 1 | System-rate clock enable |
| per_we_i | input | 4 | Write strobe for each channel's period register |
| per_wdata_i | input | 8 | Period value to write |
| ctrl_i | input | 8 | Clock source and chaining control |
| div_pulse_o | output | 4 | Divider pulse for each channel |

## Verification
A period write and a counter reload can both happen on the same clock edge. The bench provokes this by writing new period values in the very cycle in which the channel shows its pulse. It then checks that the interval which follows still uses the old value, and that the interval after that uses the new one.

A second coincidence is a lower channel reloading in the same cycle as the upper channel of its chained pair. Here the bench checks that the combined period is the product of the two period counts and that the lower channel's output stays silent.

// File: rtl/audio_div_pkg.sv
package audio_div_pkg;
  localparam int CTRL_W    = 8;
  localparam int BIT_SLOW  = 0;
  localparam int BIT_CHAIN = 4; // pair 0 uses 4, pair 1 uses 3
  localparam int BIT_FAST  = 6; // pair 0 uses 6, pair 1 uses 5

  function automatic int fast_bit(input int ch);
    return BIT_FAST - (ch / 2);
  endfunction

  function automatic int chain_bit(input int ch);
    return BIT_CHAIN - (ch / 2);
  endfunction
endpackage

// File: rtl/audio_div_prescale.sv
module audio_div_prescale #(
  parameter int FAST_DIV = 28,
  parameter int SLOW_DIV = 114
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_tick_i,
  output logic fast_tick_o,
  output logic slow_tick_o
);
  localparam int FW = $clog2(FAST_DIV);
  localparam int SW = $clog2(SLOW_DIV);
  localparam logic [FW-1:0] FAST_LAST = FW'(FAST_DIV - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [FW-1:0] fast_cnt_q;
  logic [SW-1:0] slow_cnt_q;

  assign fast_tick_o = sys_tick_i && (fast_cnt_q == FAST_LAST);
  assign slow_tick_o = sys_tick_i && (slow_cnt_q == SLOW_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_cnt_q <= '0;
      slow_cnt_q <= '0;
    end else if (sys_tick_i) begin
      fast_cnt_q <= fast_tick_o ? '0 : fast_cnt_q + 1'b1;
      slow_cnt_q <= slow_tick_o ? '0 : slow_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/audio_div_cell.sv
module audio_div_cell #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pulse_o
);
  logic [DW-1:0] period_q;
  logic [DW-1:0] cnt_q;

  assign pulse_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) period_q <= '0;
    else if (we_i) period_q <= wdata_i;
  end

  // reload uses the value held before any same-edge write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == '0) ? period_q : cnt_q - 1'b1;
  end
endmodule

// File: rtl/audio_div_bank.sv
module audio_div_bank
  import audio_div_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int DW       = 8,
  parameter int FAST_DIV = 28,
  parameter int SLOW_DIV = 114
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_tick_i,
  input  logic [N_CH-1:0]   per_we_i,
  input  logic [DW-1:0]     per_wdata_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [N_CH-1:0]   div_pulse_o
);
  logic fast_tick, slow_tick, base_tick;
  logic [N_CH-1:0] src_tick;
  logic [N_CH-1:0] raw_pulse;
  logic [N_CH-1:0] chained;

  audio_div_prescale #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_tick_i(sys_tick_i),
    .fast_tick_o(fast_tick), .slow_tick_o(slow_tick)
  );

  assign base_tick = ctrl_i[BIT_SLOW] ? slow_tick : fast_tick;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    if (ch % 2 == 0) begin : g_lo
      assign chained[ch]  = 1'b0;
      assign src_tick[ch] = ctrl_i[fast_bit(ch)] ? sys_tick_i : base_tick;
      if (ch + 1 < N_CH) begin : g_has_hi
        assign div_pulse_o[ch] = raw_pulse[ch] && !ctrl_i[chain_bit(ch + 1)];
      end else begin : g_no_hi
        assign div_pulse_o[ch] = raw_pulse[ch];
      end
    end else begin : g_hi
      assign chained[ch]     = ctrl_i[chain_bit(ch)];
      assign src_tick[ch]    = chained[ch] ? raw_pulse[ch-1] : base_tick;
      assign div_pulse_o[ch] = raw_pulse[ch];
    end

    audio_div_cell #(.DW(DW)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(src_tick[ch]),
      .we_i(per_we_i[ch]), .wdata_i(per_wdata_i),
      .pulse_o(raw_pulse[ch])
    );
  end
endmodule

// File: rtl/audio_div_bank_chk.sv
module audio_div_bank_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sys_tick_i,
  input logic [7:0] ctrl_i,
  input logic [3:0] div_pulse_o,
  input logic [3:0] raw_pulse,
  input logic       fast_tick,
  input logic       slow_tick
);
  a_r8_pulse_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o != 4'b0) |-> sys_tick_i);

  a_r6_low_silent_01: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[4] |-> !div_pulse_o[0]);

  a_r6_low_silent_23: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[3] |-> !div_pulse_o[2]);

  a_r5_hi_needs_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[4] && div_pulse_o[1]) |-> raw_pulse[0]);

  a_r3_base_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[6] && div_pulse_o[0]) |-> (ctrl_i[0] ? slow_tick : fast_tick));

  a_r9_ch1_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[4] && div_pulse_o[1]) |-> (ctrl_i[0] ? slow_tick : fast_tick));

  a_r3_fast_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_tick |=> !fast_tick);
endmodule

bind audio_div_bank audio_div_bank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_tick_i(sys_tick_i),
  .ctrl_i(ctrl_i), .div_pulse_o(div_pulse_o), .raw_pulse(raw_pulse),
  .fast_tick(fast_tick), .slow_tick(slow_tick)
);

// File: tb/audio_div_bank_tb.sv
module audio_div_bank_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sys_tick_i = 1'b0;
  logic [3:0] per_we_i = '0;
  logic [7:0] per_wdata_i = '0;
  logic [7:0] ctrl_i = '0;
  logic [3:0] div_pulse_o;
  int errors = 0;
  int checks = 0;
  bit toggle_tick = 1'b0;

  always #10 clk_i = ~clk_i;

  audio_div_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_tick_i(sys_tick_i),
    .per_we_i(per_we_i), .per_wdata_i(per_wdata_i), .ctrl_i(ctrl_i),
    .div_pulse_o(div_pulse_o)
  );

  always @(negedge clk_i) if (toggle_tick) sys_tick_i <= ~sys_tick_i;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_per(input int ch, input int val);
    per_we_i[ch] = 1'b1;
    per_wdata_i  = 8'(val);
    @(negedge clk_i);
    per_we_i = '0;
  endtask

  task automatic wait_pulse(input int ch, output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!div_pulse_o[ch] && n < 20000);
  endtask

  task automatic measure(input int ch, output int n);
    int d;
    wait_pulse(ch, d);
    wait_pulse(ch, d);
    wait_pulse(ch, n);
  endtask

  task automatic t_reset;
    int seen = 0;
    rst_ni = 1'b0; sys_tick_i = 1'b0; toggle_tick = 1'b0;
    ctrl_i = '0; per_we_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (div_pulse_o != 4'b0) seen++;
    end
    check(seen == 0, "R1 no pulse without tick", seen, 0);
    sys_tick_i = 1'b1;
  endtask

  task automatic t_base;
    int n;
    ctrl_i = 8'h00;
    write_per(0, 3);
    measure(0, n);
    check(n == 112, "R2/R3 fast base N=3", n, 112);
    write_per(3, 1);
    measure(3, n);
    check(n == 56, "R2 ch3 base N=1", n, 56);
    ctrl_i = 8'h01;
    write_per(1, 0);
    measure(1, n);
    check(n == 114, "R3 slow base N=0", n, 114);
  endtask

  task automatic t_fast;
    int n;
    ctrl_i = 8'h60;
    write_per(0, 9);
    write_per(2, 4);
    measure(0, n);
    check(n == 10, "R4 ch0 system clock", n, 10);
    measure(2, n);
    check(n == 5, "R4 ch2 system clock", n, 5);
    ctrl_i = 8'h40;
    write_per(1, 0);
    measure(1, n);
    check(n == 28, "R9 ch1 ignores bit 6", n, 28);
  endtask

  task automatic t_pulse_width;
    int n;
    ctrl_i = 8'h40;
    write_per(0, 4);
    wait_pulse(0, n);
    @(negedge clk_i);
    check(div_pulse_o[0] == 1'b0, "R2 one-cycle pulse", div_pulse_o[0], 0);
  endtask

  task automatic t_chain;
    int n, seen;
    ctrl_i = 8'h50;
    write_per(0, 2);
    write_per(1, 3);
    measure(1, n);
    check(n == 12, "R5 chain 0/1 product", n, 12);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      if (div_pulse_o[0]) seen++;
    end
    check(seen == 0, "R6 ch0 silent when chained", seen, 0);
    ctrl_i = 8'h08;
    write_per(2, 1);
    write_per(3, 1);
    measure(3, n);
    check(n == 112, "R5 chain 2/3 on base", n, 112);
    seen = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk_i);
      if (div_pulse_o[2]) seen++;
    end
    check(seen == 0, "R6 ch2 silent when chained", seen, 0);
  endtask

  task automatic t_late_write;
    int n, d;
    ctrl_i = 8'h40;
    write_per(0, 9);
    measure(0, n);
    // write lands in the same cycle as the reload
    write_per(0, 2);
    wait_pulse(0, d);
    check(d + 1 == 10, "R7 current count kept", d + 1, 10);
    wait_pulse(0, n);
    check(n == 3, "R7 new period after reload", n, 3);
  endtask

  task automatic t_gated;
    int n, bad;
    ctrl_i = 8'h40;
    write_per(0, 1);
    toggle_tick = 1'b1;
    measure(0, n);
    check(n == 4, "R8 half-rate ticks", n, 4);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      #1;
      if (div_pulse_o[0] && !sys_tick_i) bad++;
    end
    check(bad == 0, "R8 pulse only with tick", bad, 0);
    toggle_tick = 1'b0;
    @(negedge clk_i);
    sys_tick_i = 1'b1;
  endtask

  initial begin
    t_reset();
    t_base();
    t_fast();
    t_pulse_width();
    t_chain();
    t_late_write();
    t_gated();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule